// File: doc/BRIEF.md
# Register-Mapped 32-Line GPIO Port

This block is a 32-line general-purpose I/O port placed on a simple single-cycle register bus. Software configures each line through four per-line registers: a direction register, an open-drain register, an output-data register and an input-buffer-enable register. The port drives a pad output value and a pad output-enable per line. It also brings the pad inputs through a two-stage synchroniser into a sampled-input register that is read through the data register.

Register bits are numbered in reverse of line numbers: line n lives in register bit 31−n. A read of the data register mixes two sources. Output lines return the value software last wrote, held in a shadow register. Input lines return the synchronised pad level, and only if their input buffer is enabled. A parameter can mark a group of four lines at either end of the port as input-only. The port exposes line-indexed pad vectors, so `pad_oe[n]` belongs to line n.

Top module: `gpio_port32`

## Requirements
- R1: After a synchronous active-low reset every register reads 0 and `pad_oe` is all zero: every line is an input, push-pull and has its input buffer off.
- R2: Line n corresponds to register bit 31−n in every per-line register. Pad vectors are line-indexed, so writing bit 31 controls `pad_oe[0]`/`pad_out[0]`.
- R3: Direction bit 1 makes a line an output. A push-pull output line has `pad_oe` high and `pad_out` equal to its data bit. A line with direction bit 0 has `pad_oe` low.
- R4: An output line whose open-drain bit is 1 asserts `pad_oe` only while its data bit is 0. Its `pad_out` is always 0, and it releases `pad_oe` while its data bit is 1.
- R5: For an input line with its input buffer enabled, a pad change is visible in the data register (offset 0x08) after the third rising clock edge: two synchroniser flops plus the sample register.
- R6: An input line whose input-buffer-enable bit (offset 0x18) is 0 reads 0 in the data register. This takes effect in the same cycle the enable is cleared.
- R7: An output line reads back the last value written to the data register, whatever the pad input level.
- R8: With `INPUT_ONLY_SEL`=1, lines 28–31 are input-only. With `INPUT_ONLY_SEL`=2, lines 0–3 are input-only. Writes of 1 to their direction bits are ignored, those bits read 0, and their `pad_oe` stays 0.
- R9: Any offset other than 0x00, 0x04, 0x08 and 0x18 reads 0, and a write to such an offset changes no register.
- R10: The direction (0x00), open-drain (0x04) and input-buffer-enable (0x18) registers read back the last value written, subject to R8. Read data is combinational on `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, register bit order |
| bus_rdata | output | 32 | Read data for `bus_addr`, register bit order |
| pad_in | input | 32 | Pad input levels, line-indexed, asynchronous |
| pad_out | output | 32 | Pad output values, line-indexed |
| pad_oe | output | 32 | Pad output enables, line-indexed |

## Verification
Several properties hold on every cycle, and the bound checker enforces them continuously:
- an open-drain line never drives a 1;
- input-only lines never drive;
- unmapped offsets read zero;
- output lines read back their shadow value;
- disabled input buffers read zero;
- a direction write lands, with the input-only mask applied.

Other behaviour only shows up in the bench's ordered scenarios. These are the three-edge latency from pad to data register, the reversed bit-to-line mapping seen at the pads, the one-cycle lag before a re-enabled buffer shows the pad, and the contrast between the two input-only variants.

// File: rtl/gpio_port_pkg.sv
// gpio_port_pkg: shared constants, types and helpers for the 32-line port.
// Assumes a fixed 32-line port; register bit (LINES-1-n) holds line n.
package gpio_port_pkg;
    localparam int GP_LINES = 32;

    localparam int OFF_DIR = 'h00;
    localparam int OFF_ODE = 'h04;
    localparam int OFF_DAT = 'h08;
    localparam int OFF_IBE = 'h18;

    typedef logic [GP_LINES-1:0] line_vec_t;

    // Convert between register bit order and line order (self-inverse).
    function automatic line_vec_t flip(input line_vec_t v);
        line_vec_t r;
        for (int i = 0; i < GP_LINES; i++) begin
            r[i] = v[GP_LINES-1-i];
        end
        return r;
    endfunction

    // Line mask of input-only lines: sel 1 = top cnt lines, sel 2 = bottom cnt lines.
    function automatic line_vec_t input_only_mask(input int sel, input int cnt);
        line_vec_t m;
        m = '0;
        for (int i = 0; i < GP_LINES; i++) begin
            if (sel == 1 && i >= GP_LINES - cnt) m[i] = 1'b1;
            if (sel == 2 && i < cnt)             m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: multi-stage flop synchroniser for asynchronous pad inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One synchroniser stage, fed by the pad or the previous stage.
        always_ff @(posedge clk) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= d;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
// gpio_regfile: per-line configuration and shadow output registers.
// Assumes single-cycle writes with full-width data in register bit order;
// stores everything in line order. Input-only lines can never become outputs.
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int        ADDR_W  = 8,
    parameter line_vec_t RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output line_vec_t         dir_q,
    output line_vec_t         ode_q,
    output line_vec_t         dout_q,
    output line_vec_t         ibe_q
);
    line_vec_t wr_lines;
    assign wr_lines = flip(wr_data);

    // Register update on a bus write; unmapped offsets fall through untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            ode_q  <= '0;
            dout_q <= '0;
            ibe_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(OFF_DIR)) dir_q  <= wr_lines & ~RO_MASK;
            if (wr_addr == ADDR_W'(OFF_ODE)) ode_q  <= wr_lines;
            if (wr_addr == ADDR_W'(OFF_DAT)) dout_q <= wr_lines;
            if (wr_addr == ADDR_W'(OFF_IBE)) ibe_q  <= wr_lines;
        end
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
// gpio_pad_ctrl: per-line pad drive logic (push-pull or open-drain).
// Assumes line-indexed inputs; purely combinational.
module gpio_pad_ctrl
    import gpio_port_pkg::*;
(
    input  line_vec_t dir_q,
    input  line_vec_t ode_q,
    input  line_vec_t dout_q,
    output line_vec_t pad_out,
    output line_vec_t pad_oe
);
    for (genvar n = 0; n < GP_LINES; n++) begin : g_line
        // Open-drain lines only pull low; push-pull lines drive the data bit.
        assign pad_oe[n]  = dir_q[n] & ~(ode_q[n] & dout_q[n]);
        assign pad_out[n] = dout_q[n] & ~ode_q[n];
    end
endmodule

// File: rtl/gpio_rdmux.sv
// gpio_rdmux: combinational read-data selection in register bit order.
// Assumes samp_q is the synchronised sampled pad level per line.
module gpio_rdmux
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  line_vec_t         dir_q,
    input  line_vec_t         ode_q,
    input  line_vec_t         dout_q,
    input  line_vec_t         ibe_q,
    input  line_vec_t         samp_q,
    output logic [31:0]       rd_data
);
    line_vec_t data_lines;

    // Outputs read their shadow value; inputs read the gated sample.
    always_comb begin
        data_lines = (dir_q & dout_q) | (~dir_q & ibe_q & samp_q);
    end

    // Address decode; unmapped offsets read zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFF_DIR)) rd_data = flip(dir_q);
        if (rd_addr == ADDR_W'(OFF_ODE)) rd_data = flip(ode_q);
        if (rd_addr == ADDR_W'(OFF_DAT)) rd_data = flip(data_lines);
        if (rd_addr == ADDR_W'(OFF_IBE)) rd_data = flip(ibe_q);
    end
endmodule

// File: rtl/gpio_port32.sv
// gpio_port32: register-mapped 32-line GPIO port.
// Assumes a single-cycle register bus and asynchronous pad inputs. Line n sits
// at register bit 31-n. INPUT_ONLY_SEL picks which end (if any) has
// INPUT_ONLY_CNT input-only lines.
module gpio_port32
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int SYNC_STAGES    = 2,
    parameter int INPUT_ONLY_SEL = 0,
    parameter int INPUT_ONLY_CNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe
);
    localparam line_vec_t RO_MASK = input_only_mask(INPUT_ONLY_SEL, INPUT_ONLY_CNT);

    line_vec_t dir_q, ode_q, dout_q, ibe_q;
    line_vec_t pad_sync, samp_q;

    gpio_regfile #(.ADDR_W(ADDR_W), .RO_MASK(RO_MASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .ode_q   (ode_q),
        .dout_q  (dout_q),
        .ibe_q   (ibe_q)
    );

    gpio_sync #(.WIDTH(GP_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    // Sample synchronised pads into the data register, only through enabled buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= pad_sync & ibe_q;
    end

    gpio_pad_ctrl u_pads (
        .dir_q   (dir_q),
        .ode_q   (ode_q),
        .dout_q  (dout_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpio_rdmux #(.ADDR_W(ADDR_W)) u_rd (
        .rd_addr (bus_addr),
        .dir_q   (dir_q),
        .ode_q   (ode_q),
        .dout_q  (dout_q),
        .ibe_q   (ibe_q),
        .samp_q  (samp_q),
        .rd_data (bus_rdata)
    );
endmodule

// File: rtl/gpio_port32_chk.sv
// gpio_port32_chk: assertion checker bound into every gpio_port32 instance.
// Assumes it observes the configuration registers through the bind.
module gpio_port32_chk
    import gpio_port_pkg::*;
#(
    parameter int        ADDR_W  = 8,
    parameter line_vec_t RO_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pad_out,
    input logic [31:0]       pad_oe,
    input line_vec_t         dir_q,
    input line_vec_t         ode_q,
    input line_vec_t         dout_q,
    input line_vec_t         ibe_q
);
    logic mapped;
    assign mapped = (bus_addr == ADDR_W'(OFF_DIR)) || (bus_addr == ADDR_W'(OFF_ODE)) ||
                    (bus_addr == ADDR_W'(OFF_DAT)) || (bus_addr == ADDR_W'(OFF_IBE));

    AST_RESET_RELEASES: assert property (@(posedge clk) !rst_n |=> (pad_oe == '0)); // R1
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ode_q & pad_out) == '0); // R4
    AST_RO_NEVER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & RO_MASK) == '0); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0)); // R9
    AST_OUT_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_DAT)) |-> (((bus_rdata ^ flip(dout_q)) & flip(dir_q)) == '0)); // R7
    AST_IBE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_DAT)) |-> ((bus_rdata & flip(~dir_q & ~ibe_q)) == '0)); // R6
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && bus_we && bus_addr == ADDR_W'(OFF_DIR))
        |=> (dir_q == (flip($past(bus_wdata)) & ~RO_MASK))); // R10
endmodule

bind gpio_port32 gpio_port32_chk #(.ADDR_W(ADDR_W), .RO_MASK(RO_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .dir_q     (dir_q),
    .ode_q     (ode_q),
    .dout_q    (dout_q),
    .ibe_q     (ibe_q)
);

// File: tb/gpio_port32_bench.sv
// gpio_port32_bench: self-checking bench. A vector table drives the register
// configuration, then directed tests cover sampling latency, buffer gating,
// shadow readback, the low-end input-only variant and reset.
module gpio_port32_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] rdata, pout, poe;
    logic [31:0] rdata_lo, pout_lo, poe_lo;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_port32 #(.INPUT_ONLY_SEL(1)) u_gpio_port32 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_out(pout), .pad_oe(poe)
    );

    gpio_port32 #(.INPUT_ONLY_SEL(2)) u_gpio_port32_lo (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_lo), .pad_in(pad_in),
        .pad_out(pout_lo), .pad_oe(poe_lo)
    );

    // Table entry: {addr, wdata, expected readback at addr, expected pad_oe, expected pad_out}.
    // Main instance has lines 28..31 (register bits 3..0) input-only; pad vectors are line-indexed.
    localparam int NV = 9;
    localparam logic [135:0] VEC [NV] = '{
        {8'h00, 32'hF000_0000, 32'hF000_0000, 32'h0000_000F, 32'h0000_0000}, // R2 R3
        {8'h08, 32'hA000_0000, 32'hA000_0000, 32'h0000_000F, 32'h0000_0005}, // R3 R7
        {8'h04, 32'hC000_0000, 32'hC000_0000, 32'h0000_000E, 32'h0000_0004}, // R4 R10
        {8'h00, 32'h0000_000F, 32'h0000_0000, 32'h0000_0000, 32'h0000_0004}, // R8
        {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'h0FFF_FFFE, 32'h0000_0004}, // R8 R4
        {8'h0C, 32'h1234_5678, 32'h0000_0000, 32'h0FFF_FFFE, 32'h0000_0004}, // R9
        {8'h08, 32'h0000_0000, 32'h0000_0000, 32'h0FFF_FFFF, 32'h0000_0000}, // R4 R6
        {8'h18, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0FFF_FFFF, 32'h0000_0000}, // R10
        {8'h04, 32'h0000_0000, 32'h0000_0000, 32'h0FFF_FFFF, 32'h0000_0000}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One bus write; returns at the following falling edge with the strobe low.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
    endtask

    task automatic clocks(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        clocks(3);
        rst_n = 1'b1;
        // R1: reset state at every mapped offset and at the pads.
        rd(8'h00); check("R1 dir", rdata, 32'h0);
        rd(8'h04); check("R1 ode", rdata, 32'h0);
        rd(8'h08); check("R1 data", rdata, 32'h0);
        rd(8'h18); check("R1 ibe", rdata, 32'h0);
        check("R1 pad_oe", poe, 32'h0);

        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][135:128], VEC[v][127:96]);
            #1;
            check($sformatf("R2/R3/R4/R8/R9/R10 step %0d rd", v), rdata, VEC[v][95:64]);
            check($sformatf("R2/R3/R4/R8 step %0d oe", v), poe, VEC[v][63:32]);
            check($sformatf("R3/R4 step %0d out", v), pout, VEC[v][31:0]);
        end

        // R5: sampling latency through the synchroniser.
        wr(8'h00, 32'h0); wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h08); clocks(3); #1;
        check("R5 idle", rdata, 32'h0);
        @(negedge clk); pad_in = 32'h8000_0003;
        clocks(2); #1;
        check("R5 not yet after two edges", rdata, 32'h0);
        clocks(1); #1;
        check("R5 after three edges R2", rdata, 32'hC000_0001);

        // R6: clearing line 0's buffer (bit 31) hides it at once.
        wr(8'h18, 32'h7FFF_FFFF); bus_addr = 8'h08; #1;
        check("R6 disabled buffer", rdata, 32'h4000_0001);
        wr(8'h18, 32'hFFFF_FFFF); bus_addr = 8'h08; clocks(2); #1;
        check("R6 re-enabled buffer", rdata, 32'hC000_0001);

        // R7: line 0 as output reads its shadow, not the pad.
        wr(8'h00, 32'h8000_0000); wr(8'h08, 32'h0); bus_addr = 8'h08; #1;
        check("R7 shadow 0 pad 1", rdata, 32'h4000_0001);
        wr(8'h08, 32'hFFFF_FFFF); pad_in = 32'h8000_0002; bus_addr = 8'h08;
        clocks(4); #1;
        check("R7 shadow 1 pad 0", rdata, 32'hC000_0001);

        // R8: low-end variant keeps lines 0..3 (bits 31..28) as inputs.
        wr(8'h04, 32'h0); wr(8'h08, 32'h0); wr(8'h00, 32'hFFFF_FFFF); #1;
        check("R8 low variant dir", rdata_lo, 32'h0FFF_FFFF);
        check("R8 low variant oe", poe_lo, 32'hFFFF_FFF0);

        // R9: unmapped write leaves direction intact.
        wr(8'h01, 32'h0); rd(8'h00);
        check("R9 unmapped write", rdata, 32'hFFFF_FFF0);

        // R1: mid-run reset clears everything.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 mid-run dir", rdata, 32'h0);
        check("R1 mid-run oe", poe, 32'h0);
        finish_run();
    end
endmodule